// File: doc/BRIEF.md
# Pipelined Bus Cycle Sequencer

This block sequences read and write cycles for a processor on a shared bidirectional data bus. A cycle is either a single transfer or a four-beat burst. The controller raises an address strobe for one clock, then stays in a data phase until the cycle's final ready strobe arrives. A beat counter tells the final strobe apart from the earlier ones.

If the bus side raises the next-address request during a data phase, the controller may accept a second request and put its address out early. Two cycles then overlap. When the first cycle ends, the pipelined cycle becomes the current one. If the two cycles move data in opposite directions, the controller first spends exactly one clock in a turnaround state with the data drivers off, so that the bus owner can change.

The requester offers a cycle with a valid/write/burst triple and sees it taken on the accept output. The bus side supplies the ready strobe and the next-address request. The controller drives the address strobe and the data output enable, and exposes its state code.

Top module: `bus_cycle_seq`

## Requirements
- R1: While reset is low, and on the first clock after it rises, the state code is 0 (idle), the address strobe is low and the data output enable is low.
- R2: In idle, a valid request is accepted in the same cycle. The next state is 1 (address), with the address strobe high for exactly that one clock. State 2 (data) follows.
- R3: A single transfer ends on its first ready strobe and a burst ends on its fourth. If no cycle is pipelined, the end of the cycle returns the controller to idle.
- R4: In the data state, a next-address request on a clock without the final ready strobe moves the controller to state 3 (data with next address requested).
- R5: Requests are accepted only in idle, and in state 3 on a clock without the final ready strobe. An accept in state 3 leads to state 4 (pipelined address), with the address strobe high. In every other state a valid request is not accepted.
- R6: In state 4 the next-address request has no effect. The final ready strobe leads to state 6 (turnaround) when the two cycles' directions differ, and to state 2 otherwise. Any other clock leads to state 5 (pipelined data).
- R7: State 5 holds until the final ready strobe of the current cycle. On that strobe the controller goes to state 6 if the directions differ. Otherwise it goes to state 3 if the next-address request was seen in any clock of state 5, and to state 2 if it was not.
- R8: The turnaround state lasts one clock, with the data output enable low. It is followed by state 3 if the next-address request is high in that clock, and by state 2 if it is not.
- R9: The data output enable is high only when the current cycle is a write and the state is 2, 3, 4 or 5. It is low in idle, in the address state, in the turnaround state and during reads.
- R10: After a hand-over, the promoted cycle counts its ready strobes from zero. A pipelined burst therefore needs four fresh strobes to end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A cycle request is offered |
| req_write | input | 1 | Offered cycle is a write (1) or a read (0) |
| req_burst | input | 1 | Offered cycle is a four-beat burst |
| rdy | input | 1 | Ready strobe for one data beat |
| na | input | 1 | Next-address request from the bus side |
| ads | output | 1 | Address strobe |
| data_oe | output | 1 | Data bus output enable |
| req_accept | output | 1 | The offered request is taken this clock |
| state | output | 3 | Current state code (0 to 6) |

## Verification
The bench runs overlapped cycles whose directions both flip and match. A controller that skipped the turnaround would drive the bus while the other side still owned it. One that always inserted it would lose a clock on every same-direction hand-over. A next-address request is held high through the pipelined-address state, which catches a design that wrongly samples it there. Another is raised and then dropped before the final strobe in the pipelined-data state, which catches a design that forgets it. A pipelined burst follows a finished single transfer, so a beat counter that is not cleared at the hand-over would end the burst early.

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq #(
  parameter int BURST_BEATS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_write,
  input  logic       req_burst,
  input  logic       rdy,
  input  logic       na,
  output logic       ads,
  output logic       data_oe,
  output logic       req_accept,
  output logic [2:0] state
);
  localparam int BW = (BURST_BEATS > 1) ? $clog2(BURST_BEATS) : 1;
  localparam logic [2:0] S_IDLE  = 3'd0;
  localparam logic [2:0] S_ADDR  = 3'd1;
  localparam logic [2:0] S_DATA  = 3'd2;
  localparam logic [2:0] S_DNA   = 3'd3;
  localparam logic [2:0] S_PADDR = 3'd4;
  localparam logic [2:0] S_PDATA = 3'd5;
  localparam logic [2:0] S_TURN  = 3'd6;

  logic [2:0]    state_n;
  logic          cur_write, cur_burst, nxt_write, nxt_burst, na_seen;
  logic [BW-1:0] beat;
  logic          last, done, flip, pipe, promote, in_data;

  assign last    = !cur_burst || (beat == BW'(BURST_BEATS - 1));
  assign done    = rdy && last;
  assign flip    = cur_write != nxt_write;
  assign pipe    = (state == S_PADDR) || (state == S_PDATA);
  assign promote = pipe && done;
  assign in_data = (state == S_DATA) || (state == S_DNA) || pipe;

  assign ads        = (state == S_ADDR) || (state == S_PADDR);
  assign data_oe    = cur_write && in_data;
  assign req_accept = req_valid && ((state == S_IDLE) || (state == S_DNA && !done));

  always_comb begin
    state_n = state;
    case (state)
      S_IDLE:  if (req_valid) state_n = S_ADDR;
      S_ADDR:  state_n = S_DATA;
      S_DATA:  if (done) state_n = S_IDLE;
               else if (na) state_n = S_DNA;
      S_DNA:   if (done) state_n = S_IDLE;
               else if (req_valid) state_n = S_PADDR;
      S_PADDR: if (done) state_n = flip ? S_TURN : S_DATA;
               else state_n = S_PDATA;
      S_PDATA: if (done) begin
                 if (flip) state_n = S_TURN;
                 else state_n = (na || na_seen) ? S_DNA : S_DATA;
               end
      S_TURN:  state_n = na ? S_DNA : S_DATA;
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cur_write <= 1'b0;
      cur_burst <= 1'b0;
      nxt_write <= 1'b0;
      nxt_burst <= 1'b0;
      beat      <= '0;
      na_seen   <= 1'b0;
    end else begin
      state   <= state_n;
      na_seen <= (state == S_PDATA) && (na_seen || na);
      if (req_accept && state == S_IDLE) begin
        cur_write <= req_write;
        cur_burst <= req_burst;
      end else if (req_accept) begin
        nxt_write <= req_write;
        nxt_burst <= req_burst;
      end
      if (promote) begin
        cur_write <= nxt_write;
        cur_burst <= nxt_burst;
        beat      <= '0;
      end else if (state == S_IDLE) begin
        beat <= '0;
      end else if (rdy && in_data) begin
        beat <= beat + 1'b1;
      end
    end
  end
endmodule

module bus_cycle_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rdy,
  input logic       na,
  input logic       req_accept,
  input logic       ads,
  input logic       data_oe,
  input logic [2:0] state
);
  p_addr_one_clock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    state == 3'd1 |=> state == 3'd2);
  p_accept_to_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |=> (state == 3'd1 || state == 3'd4) && ads);
  p_pa_not_to_dna_r6: assert property (@(posedge clk) disable iff (!rst_n)
    state == 3'd4 |=> state != 3'd3);
  p_pdata_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd5 && !rdy) |=> state == 3'd5);
  p_turn_one_clock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd6 && na) |=> state == 3'd3);
  p_turn_plain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd6 && !na) |=> state == 3'd2);
  p_turn_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == 3'd6) |-> !data_oe && !ads);
endmodule

bind bus_cycle_seq bus_cycle_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rdy(rdy), .na(na), .req_accept(req_accept),
  .ads(ads), .data_oe(data_oe), .state(state)
);

// File: tb/bus_cycle_seq_bench.sv
module bus_cycle_seq_bench;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_burst = 0, rdy = 0, na = 0;
  logic ads, data_oe, req_accept;
  logic [2:0] state;

  typedef struct {
    logic [2:0] st;
    logic       oe;
    string      tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  bus_cycle_seq u_bus_cycle_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_burst(req_burst), .rdy(rdy), .na(na), .ads(ads), .data_oe(data_oe),
    .req_accept(req_accept), .state(state)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk({1'b0, state}, {1'b0, e.st}, {e.tag, " state"});
      chk({3'b0, ads}, {3'b0, (e.st == 3'd1 || e.st == 3'd4)}, {e.tag, " ads"});
      chk({3'b0, data_oe}, {3'b0, e.oe}, {e.tag, " data_oe"});
    end
  end

  task automatic step(input logic v, w, b, r, n, acc,
                      input logic [2:0] st, input logic oe, input string tag);
    exp_t e;
    req_valid = v; req_write = w; req_burst = b; rdy = r; na = n;
    #1;
    chk({3'b0, req_accept}, {3'b0, acc}, {tag, " req_accept"});
    e.st = st; e.oe = oe; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({1'b0, state}, 4'd0, "R1 reset state");
    chk({3'b0, ads}, 4'd0, "R1 reset ads");
    chk({3'b0, data_oe}, 4'd0, "R1 reset oe");
    rst_n = 1'b1;
    // single read
    step(1,0,0,0,0, 1, 3'd1, 0, "R2 idle accept");
    step(0,0,0,0,0, 0, 3'd2, 0, "R2 addr to data");
    step(0,0,0,1,0, 0, 3'd0, 0, "R3 single ends");
    // burst write
    step(1,1,1,0,0, 1, 3'd1, 0, "R9 addr oe low");
    step(1,0,0,0,0, 0, 3'd2, 1, "R5 no accept in addr");
    step(0,0,0,1,0, 0, 3'd2, 1, "R3 beat1");
    step(0,0,0,1,0, 0, 3'd2, 1, "R3 beat2");
    step(0,0,0,1,0, 0, 3'd2, 1, "R3 beat3");
    step(0,0,0,1,0, 0, 3'd0, 0, "R3 burst ends");
    // write then read, turnaround from pipelined address
    step(1,1,0,0,0, 1, 3'd1, 0, "R2 write req");
    step(0,0,0,0,0, 0, 3'd2, 1, "R9 write data");
    step(1,0,0,0,1, 0, 3'd3, 1, "R4 na in data");
    step(1,0,0,0,0, 1, 3'd4, 1, "R5 pipelined accept");
    step(0,0,0,1,0, 0, 3'd6, 0, "R6 flip to turn");
    step(0,0,0,0,0, 0, 3'd2, 0, "R8 turn to data");
    step(0,0,0,1,0, 0, 3'd0, 0, "R3 read ends");
    // read then read burst, pipelined data with na seen earlier
    step(1,0,0,0,0, 1, 3'd1, 0, "R2 read req");
    step(0,0,0,0,0, 0, 3'd2, 0, "R9 read oe low");
    step(0,0,0,0,1, 0, 3'd3, 0, "R4 na");
    step(1,0,1,0,1, 1, 3'd4, 0, "R5 burst pipelined");
    step(0,0,0,0,1, 0, 3'd5, 0, "R6 na ignored");
    step(1,0,0,0,1, 0, 3'd5, 0, "R5 no accept pipe data");
    step(0,0,0,1,0, 0, 3'd3, 0, "R7 na seen earlier");
    step(0,0,0,1,0, 0, 3'd3, 0, "R10 beat1");
    step(0,0,0,1,0, 0, 3'd3, 0, "R10 beat2");
    step(0,0,0,1,0, 0, 3'd3, 0, "R10 beat3");
    step(0,0,0,1,0, 0, 3'd0, 0, "R10 burst ends");
    // write then write, no turnaround
    step(1,1,0,0,0, 1, 3'd1, 0, "R2 write req");
    step(0,0,0,0,1, 0, 3'd2, 1, "R2 data");
    step(0,0,0,0,1, 0, 3'd3, 1, "R4 na");
    step(1,1,0,0,0, 1, 3'd4, 1, "R5 second write");
    step(0,0,0,1,1, 0, 3'd2, 1, "R6 same dir to data");
    step(0,0,0,1,0, 0, 3'd0, 0, "R3 ends");
    // burst write then read, turnaround from pipelined data
    step(1,1,1,0,0, 1, 3'd1, 0, "R2 burst write");
    step(0,0,0,0,0, 0, 3'd2, 1, "R9 data");
    step(0,0,0,1,1, 0, 3'd3, 1, "R4 na with beat");
    step(1,0,0,0,0, 1, 3'd4, 1, "R5 read pipelined");
    step(0,0,0,1,0, 0, 3'd5, 1, "R6 not last to pipe data");
    step(0,0,0,1,0, 0, 3'd5, 1, "R7 hold");
    step(0,0,0,1,0, 0, 3'd6, 0, "R7 flip to turn");
    step(0,0,0,0,1, 0, 3'd3, 0, "R8 na in turn");
    step(0,0,0,1,0, 0, 3'd0, 0, "R3 read ends");
    step(0,0,0,0,0, 0, 3'd0, 0, "R1 idle rest");
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule